// File: doc/BRIEF.md
# Protected Memory Range Access Checker

This block guards one reserved memory region that is described by a base/mask register pair. A small configuration port writes the two registers. It accepts only two memory-type encodings and can lock the pair so that it cannot be reprogrammed. Every write that is refused raises a general-protection fault and reports a cause code.

The access side is purely combinational. It takes an address, an access kind (data or instruction fetch), a read/write flag, a secure-mode flag, the memory type supplied by the rest of the memory system, and one cache-disable bit per logical processor on the core. From these it produces the effective memory type. It also reports one of two exceptional outcomes: an abort-page indication (reads return all ones, writes are dropped) or a fault with error code zero.

Top module: `prot_range_checker`

## Requirements
- R1: After reset, both registers read as zero and no address hits the range, because the valid bit is clear.
- R2: A base write is accepted only when its type field (bits 7:0) is 0x00 (uncacheable) or 0x06 (write-back). Any other type raises `cfg_fault` with `cfg_err` = 1 and leaves the base register unchanged.
- R3: An address hits the range when mask bit 11 (valid) is set and, for every address bit from 12 upward, the address and the base agree wherever the mask bit is one.
- R4: A secure access that hits the range gets the programmed range type as its effective type, whatever the value of `ext_mtype`.
- R5: When any bit of `cd_lp` is set, the override is suppressed and `eff_mtype` equals `ext_mtype`.
- R6: A non-secure access that hits the range asserts `acc_abort`. It also asserts `acc_rd_ones` for a read or `acc_wr_drop` for a write.
- R7: A secure instruction fetch that misses the range asserts `acc_fault` with `acc_fault_code` = 0.
- R8: Writing mask bit 10 (lock) sets the lock. After that, every base or mask write raises `cfg_fault` with `cfg_err` = 2, the lock cause taking priority over a bad type, and both registers stay unchanged.
- R9: An accepted write becomes visible at the clock edge that samples the strobe. An access in that same cycle is still classified with the old contents.
- R10: An access that misses the range and is not a secure fetch passes `ext_mtype` through, with no abort and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 mask |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_fault | output | 1 | General-protection fault on the current write |
| cfg_err | output | 2 | Fault cause: 0 none, 1 bad type, 2 locked |
| cfg_base | output | ADDR_W | Base register contents |
| cfg_mask | output | ADDR_W | Mask register contents |
| acc_addr | input | ADDR_W | Access address |
| acc_secure | input | 1 | Access issued in secure mode |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_write | input | 1 | Access is a write |
| ext_mtype | input | 8 | Memory type from the other sources |
| cd_lp | input | NUM_LP | Cache-disable, one bit per logical processor |
| eff_mtype | output | 8 | Effective memory type |
| acc_abort | output | 1 | Abort-page semantics apply |
| acc_rd_ones | output | 1 | Read data is to be forced to all ones |
| acc_wr_drop | output | 1 | Write is to be discarded |
| acc_fault | output | 1 | Fetch fault |
| acc_fault_code | output | 16 | Fault error code |

## Verification
A register write and an access classification can happen in the same cycle. In that case the access must still see the register contents from before the write.

The bench provokes this by strobing a base write that changes the type from write-back to uncacheable while a secure access hits the range. It expects write-back in that cycle and uncacheable one cycle later. A second collision, a lock refusal and a bad type in a single write, is judged by the reported cause.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;
  localparam int TYPE_W    = 8;
  localparam int VALID_BIT = 11;
  localparam int LOCK_BIT  = 10;
  localparam logic [TYPE_W-1:0] MT_UC = 8'h00;
  localparam logic [TYPE_W-1:0] MT_WB = 8'h06;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_TYPE = 2'd1,
    ERR_LOCK = 2'd2
  } cfg_err_e;

  function automatic logic type_legal(input logic [TYPE_W-1:0] t);
    return (t == MT_UC) || (t == MT_WB);
  endfunction
endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_range_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int PG_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              fault,
  output logic [1:0]        err
);
  localparam logic [ADDR_W-1:0] HI_BITS   = {ADDR_W{1'b1}} << PG_SHIFT;
  localparam logic [ADDR_W-1:0] BASE_KEEP = HI_BITS | ADDR_W'({TYPE_W{1'b1}});
  localparam logic [ADDR_W-1:0] MASK_KEEP = HI_BITS | (ADDR_W'(1) << VALID_BIT)
                                                    | (ADDR_W'(1) << LOCK_BIT);

  logic              locked;
  logic              base_en, mask_en;
  logic [ADDR_W-1:0] base_d, mask_d;
  cfg_err_e          err_c;

  assign locked = mask_q[LOCK_BIT];

  // next-state logic
  always_comb begin
    err_c   = ERR_NONE;
    base_en = 1'b0;
    mask_en = 1'b0;
    base_d  = wdata & BASE_KEEP;
    mask_d  = wdata & MASK_KEEP;
    if (we) begin
      if (locked)                                  err_c = ERR_LOCK;
      else if (!sel && !type_legal(wdata[TYPE_W-1:0])) err_c = ERR_TYPE;
      else if (!sel)                               base_en = 1'b1;
      else                                         mask_en = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign fault = (err_c != ERR_NONE);
  assign err   = err_c;

  // R2
  base_type_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    type_legal(base_q[TYPE_W-1:0]));
  // R2
  bad_type_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel && !type_legal(wdata[TYPE_W-1:0])) |=> $stable(base_q));
  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && we) |=> ($stable(base_q) && $stable(mask_q)));
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/prot_range_match.sv
module prot_range_match #(
  parameter int HI_W = 28
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] base_hi,
  input  logic [HI_W-1:0] mask_hi,
  input  logic            valid,
  output logic            hit
);
  logic [HI_W-1:0] miss_bit;

  for (genvar i = 0; i < HI_W; i++) begin : g_bit
    assign miss_bit[i] = mask_hi[i] & (addr_hi[i] ^ base_hi[i]);
  end

  assign hit = valid & ~|miss_bit;
endmodule

// File: rtl/prot_access_classify.sv
module prot_access_classify
  import prot_range_pkg::*;
#(
  parameter int NUM_LP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              secure,
  input  logic              fetch,
  input  logic              is_write,
  input  logic [TYPE_W-1:0] ext_mtype,
  input  logic [TYPE_W-1:0] range_mtype,
  input  logic [NUM_LP-1:0] cd_lp,
  output logic [TYPE_W-1:0] eff_mtype,
  output logic              abort,
  output logic              rd_ones,
  output logic              wr_drop,
  output logic              fault,
  output logic [15:0]       fault_code
);
  logic cd_any;
  assign cd_any = |cd_lp;

  always_comb begin
    eff_mtype  = ext_mtype;
    abort      = 1'b0;
    fault      = 1'b0;
    fault_code = 16'h0000;
    if (hit && secure && !cd_any) eff_mtype = range_mtype;
    if (hit && !secure)           abort     = 1'b1;
    if (!hit && secure && fetch)  fault     = 1'b1;
  end

  assign rd_ones = abort & ~is_write;
  assign wr_drop = abort &  is_write;

  // R6
  abort_nonsecure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!secure && hit));
  // R7
  fault_secure_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (secure && fetch && !hit && fault_code == 16'h0000));
  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort, fault}) && $onehot0({rd_ones, wr_drop}));
  // R5
  cd_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cd_any |-> (eff_mtype == ext_mtype));
endmodule

// File: rtl/prot_range_checker.sv
module prot_range_checker
  import prot_range_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int PG_SHIFT = 12,
  parameter int NUM_LP   = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_fault,
  output logic [1:0]        cfg_err,
  output logic [ADDR_W-1:0] cfg_base,
  output logic [ADDR_W-1:0] cfg_mask,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  input  logic              acc_fetch,
  input  logic              acc_write,
  input  logic [7:0]        ext_mtype,
  input  logic [NUM_LP-1:0] cd_lp,
  output logic [7:0]        eff_mtype,
  output logic              acc_abort,
  output logic              acc_rd_ones,
  output logic              acc_wr_drop,
  output logic              acc_fault,
  output logic [15:0]       acc_fault_code
);
  localparam int HI_W = ADDR_W - PG_SHIFT;

  logic              rst_n;
  logic [ADDR_W-1:0] base_q, mask_q;
  logic              hit;
  logic              unused_low;

  prot_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  prot_cfg_regs #(.ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q), .fault(cfg_fault), .err(cfg_err)
  );

  prot_range_match #(.HI_W(HI_W)) u_match (
    .addr_hi(acc_addr[ADDR_W-1:PG_SHIFT]), .base_hi(base_q[ADDR_W-1:PG_SHIFT]),
    .mask_hi(mask_q[ADDR_W-1:PG_SHIFT]), .valid(mask_q[VALID_BIT]), .hit(hit)
  );

  prot_access_classify #(.NUM_LP(NUM_LP)) u_cls (
    .clk(clk), .rst_n(rst_n), .hit(hit), .secure(acc_secure), .fetch(acc_fetch),
    .is_write(acc_write), .ext_mtype(ext_mtype), .range_mtype(base_q[TYPE_W-1:0]),
    .cd_lp(cd_lp), .eff_mtype(eff_mtype), .abort(acc_abort), .rd_ones(acc_rd_ones),
    .wr_drop(acc_wr_drop), .fault(acc_fault), .fault_code(acc_fault_code)
  );

  assign unused_low = ^{acc_addr[PG_SHIFT-1:0], base_q[PG_SHIFT-1:TYPE_W], mask_q[PG_SHIFT-1:0]};
  assign cfg_base   = base_q;
  assign cfg_mask   = mask_q;
endmodule

// File: tb/prot_range_checker_tb_top.sv
module prot_range_checker_tb_top;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          cfg_we, cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          cfg_fault;
  logic [1:0]    cfg_err;
  logic [AW-1:0] cfg_base, cfg_mask;
  logic [AW-1:0] acc_addr;
  logic          acc_secure, acc_fetch, acc_write;
  logic [7:0]    ext_mtype;
  logic [1:0]    cd_lp;
  logic [7:0]    eff_mtype;
  logic          acc_abort, acc_rd_ones, acc_wr_drop, acc_fault;
  logic [15:0]   acc_fault_code;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [AW-1:0] IN_A  = 40'h0089001234;
  localparam logic [AW-1:0] OUT_A = 40'h0090000000;
  localparam logic [AW-1:0] MASK_V = 40'hFFF0000800;

  always #10 clk = ~clk;

  prot_range_checker #(.ADDR_W(AW), .PG_SHIFT(12), .NUM_LP(2)) dut_i (
    .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_fault(cfg_fault), .cfg_err(cfg_err),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .acc_addr(acc_addr),
    .acc_secure(acc_secure), .acc_fetch(acc_fetch), .acc_write(acc_write),
    .ext_mtype(ext_mtype), .cd_lp(cd_lp), .eff_mtype(eff_mtype),
    .acc_abort(acc_abort), .acc_rd_ones(acc_rd_ones), .acc_wr_drop(acc_wr_drop),
    .acc_fault(acc_fault), .acc_fault_code(acc_fault_code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] d,
                           input logic exp_f, input logic [1:0] exp_e, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    #2;
    chk({req, " fault"}, 64'(cfg_fault), 64'(exp_f));
    chk({req, " cause"}, 64'(cfg_err), 64'(exp_e));
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_acc(input logic [AW-1:0] a, input logic sec, input logic fe,
                           input logic wr, input logic [7:0] ext, input logic [1:0] cd);
    @(negedge clk);
    acc_addr = a; acc_secure = sec; acc_fetch = fe; acc_write = wr;
    ext_mtype = ext; cd_lp = cd;
    #2;
  endtask

  task automatic t_reset;
    chk("R1 base", 64'(cfg_base), 64'h0);
    chk("R1 mask", 64'(cfg_mask), 64'h0);
    drive_acc(40'h0, 1'b0, 1'b0, 1'b0, 8'h04, 2'b00);
    chk("R1 no abort", 64'(acc_abort), 64'h0);
  endtask

  task automatic t_type;
    cfg_write(1'b0, 40'h0088000003, 1'b1, 2'd1, "R2 bad type");
    chk("R2 base kept", 64'(cfg_base), 64'h0);
    cfg_write(1'b0, 40'h0088000000, 1'b0, 2'd0, "R2 uc");
    chk("R2 uc stored", 64'(cfg_base), 64'h0088000000);
    cfg_write(1'b0, 40'h0088000006, 1'b0, 2'd0, "R2 wb");
    chk("R2 wb stored", 64'(cfg_base), 64'h0088000006);
  endtask

  task automatic t_match;
    drive_acc(IN_A, 1'b0, 1'b0, 1'b0, 8'h01, 2'b00);
    chk("R3 invalid mask no hit", 64'(acc_abort), 64'h0);
    cfg_write(1'b1, MASK_V, 1'b0, 2'd0, "R3 mask write");
    drive_acc(IN_A, 1'b0, 1'b0, 1'b0, 8'h01, 2'b00);
    chk("R3 hit", 64'(acc_abort), 64'h1);
    drive_acc(OUT_A, 1'b0, 1'b0, 1'b0, 8'h01, 2'b00);
    chk("R3 miss", 64'(acc_abort), 64'h0);
  endtask

  task automatic t_override;
    drive_acc(IN_A, 1'b1, 1'b0, 1'b0, 8'h00, 2'b00);
    chk("R4 range type", 64'(eff_mtype), 64'h06);
    drive_acc(IN_A, 1'b1, 1'b1, 1'b0, 8'h05, 2'b00);
    chk("R4 fetch range type", 64'(eff_mtype), 64'h06);
    chk("R4 in-range fetch no fault", 64'(acc_fault), 64'h0);
  endtask

  task automatic t_cd;
    drive_acc(IN_A, 1'b1, 1'b0, 1'b0, 8'h04, 2'b10);
    chk("R5 cd lp1", 64'(eff_mtype), 64'h04);
    drive_acc(IN_A, 1'b1, 1'b0, 1'b0, 8'h01, 2'b01);
    chk("R5 cd lp0", 64'(eff_mtype), 64'h01);
  endtask

  task automatic t_abort;
    drive_acc(IN_A, 1'b0, 1'b0, 1'b0, 8'h06, 2'b00);
    chk("R6 read ones", 64'({acc_abort, acc_rd_ones, acc_wr_drop}), 64'b110);
    drive_acc(IN_A, 1'b0, 1'b0, 1'b1, 8'h06, 2'b00);
    chk("R6 write drop", 64'({acc_abort, acc_rd_ones, acc_wr_drop}), 64'b101);
  endtask

  task automatic t_fetch_fault;
    drive_acc(OUT_A, 1'b1, 1'b1, 1'b0, 8'h06, 2'b00);
    chk("R7 fault", 64'(acc_fault), 64'h1);
    chk("R7 code", 64'(acc_fault_code), 64'h0);
    drive_acc(OUT_A, 1'b1, 1'b0, 1'b0, 8'h05, 2'b00);
    chk("R10 secure data miss", 64'({acc_fault, acc_abort, eff_mtype}), 64'h005);
    drive_acc(OUT_A, 1'b0, 1'b1, 1'b0, 8'h04, 2'b00);
    chk("R10 nonsecure fetch miss", 64'({acc_fault, acc_abort, eff_mtype}), 64'h004);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    acc_addr = IN_A; acc_secure = 1'b1; acc_fetch = 1'b0; acc_write = 1'b0;
    ext_mtype = 8'h04; cd_lp = 2'b00;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 40'h0088000000;
    #2;
    chk("R9 old type in write cycle", 64'(eff_mtype), 64'h06);
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
    chk("R9 new type next cycle", 64'(eff_mtype), 64'h00);
  endtask

  task automatic t_lock;
    cfg_write(1'b1, MASK_V | 40'h400, 1'b0, 2'd0, "R8 lock set");
    cfg_write(1'b0, 40'h0088000006, 1'b1, 2'd2, "R8 base refused");
    cfg_write(1'b1, 40'hFF00000800, 1'b1, 2'd2, "R8 mask refused");
    cfg_write(1'b0, 40'h0088000007, 1'b1, 2'd2, "R8 lock over bad type");
    chk("R8 base kept", 64'(cfg_base), 64'h0088000000);
    chk("R8 mask kept", 64'(cfg_mask), 64'(MASK_V | 40'h400));
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    acc_addr = '0; acc_secure = 1'b0; acc_fetch = 1'b0; acc_write = 1'b0;
    ext_mtype = 8'h00; cd_lp = 2'b00;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_type();
    t_match();
    t_override();
    t_cd();
    t_abort();
    t_fetch_fault();
    t_same_cycle();
    t_lock();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule